// File: doc/BRIEF.md
# Two-Bit Opcode Stack Processor

A very small stack machine whose whole instruction set is four operations: bitwise NAND, a rotate right through a carry bit, a conditional store and an inline literal push. The top of stack (T) and the entry beneath it (N) are registers. Below N sits an eight-entry ring of stack storage. No opcode is reserved for branching. A program jumps by storing a target to the reserved program-counter address 0xFFFF with an all-ones flag. That saving is why each opcode fits in two bits, and why one 16-bit memory word carries eight of them.

The processor talks to one synchronous memory port. The port returns read data one cycle after the address, and a write takes effect at the clock edge where write enable is high. Instruction words, literal words and stored data all share this port. The processor fetches a word and then runs its eight slots in order. A literal reads the next word after the current position and steps the program counter past it.

Top module: `stk_cpu`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, mem_we_o is 0 and mem_addr_o is 0. Reset clears PC, T, N, the carry bit and every ring entry to zero.
- R2: Fetching an instruction word takes two cycles. The first drives mem_addr_o = PC, and then PC advances by one. The word is executed as eight 2-bit slots, bits [1:0] first and bits [15:14] last. The encodings are 00 = NAND, 01 = SHR, 10 = STORE and 11 = LIT. After the last slot the next word is fetched.
- R3: LIT takes two cycles. The first drives mem_addr_o = PC, and the word read is then pushed as the new T. PC then advances by one, so the literal is never executed as an instruction.
- R4: NAND takes one cycle. It replaces T with ~(T & N) and pops one entry, so the old ring top becomes N.
- R5: SHR takes one cycle. It rotates T right by one bit, with the carry bit going into bit 15 and the old bit 0 of T becoming the new carry.
- R6: STORE takes one cycle and pops three entries: the flag (T), the value (N) and the address (the ring top). With a zero flag and an address other than 0xFFFF, it drives mem_we_o = 1, mem_addr_o = address and mem_wdata_o = value.
- R7: A STORE whose flag is nonzero and whose address is not 0xFFFF writes nothing and still pops three entries.
- R8: A STORE with address 0xFFFF and flag 0xFFFF loads the value into PC. It abandons the rest of the current word, and the next cycle is a fetch from the new PC.
- R9: A STORE with address 0xFFFF and any other flag neither writes memory nor changes PC.
- R10: The ring below N holds 8 entries. A push beyond 8 overwrites the oldest entry. A pop from an empty ring reads back ring entries in reverse order, without any error indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 16 | Memory address for fetch, literal read or store |
| mem_wdata_o | output | 16 | Store data |
| mem_we_o | output | 1 | Write enable, high for one cycle per performed store |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the address |

## Verification
The store opcode decodes two functions in the same cycle: an ordinary memory write and a program-counter load. Only the address and the flag decide which one happens. Directed programs aim STORE at 0xFFFF with flags of zero, of all ones and of other values, and aim ordinary addresses with nonzero flags. Random programs add many more such collisions. A behavioural model predicts the port activity of every cycle: where write enable must stay low, which address the next fetch uses, and which literals or slots are skipped. Each cycle is compared against that prediction.

// File: rtl/stk_cpu_pkg.sv
package stk_cpu_pkg;
  typedef enum logic [1:0] {
    OP_NAND  = 2'b00,
    OP_SHR   = 2'b01,
    OP_STORE = 2'b10,
    OP_LIT   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_LOAD,
    ST_EXEC,
    ST_LITW
  } state_e;

  typedef enum logic [2:0] {
    SK_HOLD,
    SK_PUSH,
    SK_POP1,
    SK_REPL,
    SK_POP3
  } stk_op_e;
endpackage

// File: rtl/stk_cpu_alu.sv
module stk_cpu_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] t_i,
  input  logic [DW-1:0] n_i,
  input  logic          carry_i,
  output logic [DW-1:0] nand_o,
  output logic [DW-1:0] shr_o,
  output logic          shr_c_o
);
  assign nand_o  = ~(t_i & n_i);
  assign shr_o   = {carry_i, t_i[DW-1:1]};
  assign shr_c_o = t_i[0];
endmodule

// File: rtl/stk_cpu_stack.sv
module stk_cpu_stack
  import stk_cpu_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  stk_op_e       op_i,
  input  logic [DW-1:0] val_i,
  output logic [DW-1:0] t_o,
  output logic [DW-1:0] n_o,
  output logic [DW-1:0] below_o
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] stk_q [DEPTH];
  logic [DW-1:0] t_q, n_q;
  logic [PW-1:0] sp_q;

  assign t_o     = t_q;
  assign n_o     = n_q;
  assign below_o = stk_q[sp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q  <= '0;
      n_q  <= '0;
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else begin
      unique case (op_i)
        SK_PUSH: begin
          stk_q[sp_q + PW'(1)] <= n_q;
          sp_q <= sp_q + PW'(1);
          n_q  <= t_q;
          t_q  <= val_i;
        end
        SK_POP1: begin
          t_q  <= val_i;
          n_q  <= stk_q[sp_q];
          sp_q <= sp_q - PW'(1);
        end
        SK_REPL: t_q <= val_i;
        SK_POP3: begin
          t_q  <= stk_q[sp_q - PW'(1)];
          n_q  <= stk_q[sp_q - PW'(2)];
          sp_q <= sp_q - PW'(3);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stk_cpu_ctrl.sv
module stk_cpu_ctrl
  import stk_cpu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] t_i,
  input  logic [DW-1:0] n_i,
  input  logic [DW-1:0] below_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] nand_i,
  input  logic [DW-1:0] shr_i,
  input  logic          shr_c_i,
  output logic          carry_o,
  output stk_op_e       stk_op_o,
  output logic [DW-1:0] stk_val_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o
);
  localparam int SLOTS = DW / 2;
  localparam int SW    = $clog2(SLOTS);

  state_e        state_q, state_d;
  logic [DW-1:0] pc_q, pc_d, ir_q, ir_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          carry_q, carry_d;
  logic          adv;
  op_e           cur_op;
  logic          is_pc, do_jump, do_wr;

  assign cur_op      = op_e'(ir_q[{slot_q, 1'b0} +: 2]);
  assign is_pc       = (below_i == '1);
  assign do_jump     = is_pc && (t_i == '1);
  assign do_wr       = !is_pc && (t_i == '0);
  assign carry_o     = carry_q;
  assign mem_wdata_o = n_i;

  always_comb begin
    state_d    = state_q;
    pc_d       = pc_q;
    ir_d       = ir_q;
    slot_d     = slot_q;
    carry_d    = carry_q;
    stk_op_o   = SK_HOLD;
    stk_val_o  = nand_i;
    mem_addr_o = pc_q;
    mem_we_o   = 1'b0;
    adv        = 1'b0;
    unique case (state_q)
      ST_FETCH: state_d = ST_LOAD;
      ST_LOAD: begin
        ir_d    = rdata_i;
        pc_d    = pc_q + DW'(1);
        slot_d  = '0;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        unique case (cur_op)
          OP_NAND: begin
            stk_op_o = SK_POP1;
            adv      = 1'b1;
          end
          OP_SHR: begin
            stk_op_o  = SK_REPL;
            stk_val_o = shr_i;
            carry_d   = shr_c_i;
            adv       = 1'b1;
          end
          OP_STORE: begin
            stk_op_o = SK_POP3;
            if (do_wr) begin
              mem_we_o   = 1'b1;
              mem_addr_o = below_i;
            end
            if (do_jump) begin
              pc_d    = n_i;
              state_d = ST_FETCH;
            end else begin
              adv = 1'b1;
            end
          end
          OP_LIT: state_d = ST_LITW;
          default: ;
        endcase
      end
      ST_LITW: begin
        stk_op_o  = SK_PUSH;
        stk_val_o = rdata_i;
        pc_d      = pc_q + DW'(1);
        adv       = 1'b1;
      end
      default: state_d = ST_FETCH;
    endcase
    if (adv) begin
      if (slot_q == SW'(SLOTS - 1)) begin
        state_d = ST_FETCH;
      end else begin
        slot_d  = slot_q + SW'(1);
        state_d = ST_EXEC;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      slot_q  <= '0;
      carry_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ir_q    <= ir_d;
      slot_q  <= slot_d;
      carry_q <= carry_d;
    end
  end
endmodule

// File: rtl/stk_cpu.sv
module stk_cpu
  import stk_cpu_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  input  logic [DW-1:0] mem_rdata_i
);
  logic [DW-1:0] t, n, below, stk_val, nand_v, shr_v;
  logic          carry, shr_c;
  stk_op_e       stk_op;

  stk_cpu_ctrl #(.DW(DW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .t_i        (t),
    .n_i        (n),
    .below_i    (below),
    .rdata_i    (mem_rdata_i),
    .nand_i     (nand_v),
    .shr_i      (shr_v),
    .shr_c_i    (shr_c),
    .carry_o    (carry),
    .stk_op_o   (stk_op),
    .stk_val_o  (stk_val),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_we_o   (mem_we_o)
  );

  stk_cpu_stack #(.DW(DW), .DEPTH(DEPTH)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (stk_op),
    .val_i  (stk_val),
    .t_o    (t),
    .n_o    (n),
    .below_o(below)
  );

  stk_cpu_alu #(.DW(DW)) u_alu (
    .t_i    (t),
    .n_i    (n),
    .carry_i(carry),
    .nand_o (nand_v),
    .shr_o  (shr_v),
    .shr_c_o(shr_c)
  );
endmodule

// File: rtl/stk_cpu_chk.sv
module stk_cpu_chk
  import stk_cpu_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input state_e        state_q,
  input op_e           cur_op,
  input logic [DW-1:0] pc_q,
  input logic          carry_q,
  input logic [DW-1:0] t_i,
  input logic [DW-1:0] n_i,
  input logic [DW-1:0] below_i,
  input logic [DW-1:0] mem_addr_o,
  input logic          mem_we_o
);
  AST_FETCH_READS_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FETCH |-> mem_addr_o == pc_q && !mem_we_o); // R2
  AST_WE_ONLY_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> state_q == ST_EXEC && cur_op == OP_STORE && t_i == '0); // R6
  AST_NO_PC_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o != '1); // R9
  AST_JUMP_LOADS_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_EXEC && cur_op == OP_STORE && below_i == '1 && t_i == '1
    |=> state_q == ST_FETCH && pc_q == $past(n_i)); // R8
  AST_LIT_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LITW |=> pc_q == $past(pc_q) + DW'(1)); // R3
  AST_SHR_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_EXEC && cur_op == OP_SHR |=> carry_q == $past(t_i[0])); // R5
  AST_NAND_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_EXEC && cur_op == OP_NAND |=> t_i == ~($past(t_i) & $past(n_i))); // R4
endmodule

bind stk_cpu_ctrl stk_cpu_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .state_q   (state_q),
  .cur_op    (cur_op),
  .pc_q      (pc_q),
  .carry_q   (carry_q),
  .t_i       (t_i),
  .n_i       (n_i),
  .below_i   (below_i),
  .mem_addr_o(mem_addr_o),
  .mem_we_o  (mem_we_o)
);

// File: tb/stk_cpu_test.sv
module stk_cpu_test;
  localparam int NCYC  = 1200;
  localparam int MAXTR = NCYC + 8;
  localparam int K_RD = 0, K_ID = 1, K_WR = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr, wdata, rdata;
  logic        we;
  int          checks = 0, failures = 0;
  bit          done = 0;

  logic [15:0] mem [0:1023];
  logic [15:0] mm  [0:1023];

  int          tr_kind [MAXTR];
  logic [15:0] tr_addr [MAXTR];
  logic [15:0] tr_data [MAXTR];
  string       tr_tag  [MAXTR];
  int          tk;

  always #5 clk = ~clk;

  stk_cpu uut (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_we_o(we), .mem_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (we) mem[addr[9:0]] <= wdata;
    rdata <= mem[addr[9:0]];
  end

  function automatic logic [15:0] enc(string s);
    logic [15:0] w = '0;
    for (int i = 0; i < s.len() && i < 8; i++) begin
      case (s[i])
        "R": w[2*i +: 2] = 2'b01;
        "S": w[2*i +: 2] = 2'b10;
        "L": w[2*i +: 2] = 2'b11;
        default: w[2*i +: 2] = 2'b00;
      endcase
    end
    return w;
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) begin
      mem[i] = '0;
      mm[i]  = '0;
    end
  endtask

  task automatic pw(int a, logic [15:0] w);
    mem[a] = w;
    mm[a]  = w;
  endtask

  function automatic void put(int kind, logic [15:0] a, logic [15:0] d, string tag);
    if (tk < MAXTR) begin
      tr_kind[tk] = kind;
      tr_addr[tk] = a;
      tr_data[tk] = d;
      tr_tag[tk]  = tag;
    end
    tk++;
  endfunction

  // behavioural instruction-level model unrolled into a per-cycle port trace
  task automatic build_trace();
    logic [15:0] pc = '0, t = '0, n = '0, ir, a, v, f, st[8];
    logic        c = 1'b0, oc;
    int          sp = 0, depth = 0;
    bit          jumped;
    for (int i = 0; i < 8; i++) st[i] = '0;
    tk = 0;
    while (tk < NCYC) begin
      put(K_RD, pc, 0, "R2");
      put(K_ID, 0, 0, "R2");
      ir = mm[pc[9:0]];
      pc = pc + 1;
      jumped = 0;
      for (int s = 0; s < 8 && !jumped; s++) begin
        case (ir[2*s +: 2])
          2'b00: begin
            put(K_ID, 0, 0, depth == 0 ? "R10" : "R4");
            t = ~(t & n);
            n = st[sp];
            sp = (sp + 7) % 8;
            depth = (depth > 0) ? depth - 1 : 0;
          end
          2'b01: begin
            put(K_ID, 0, 0, "R5");
            oc = t[0];
            t  = {c, t[15:1]};
            c  = oc;
          end
          2'b10: begin
            a = st[sp]; v = n; f = t;
            t = st[(sp + 7) % 8];
            n = st[(sp + 6) % 8];
            sp = (sp + 5) % 8;
            depth = (depth > 2) ? depth - 3 : 0;
            if (a == 16'hFFFF) begin
              if (f == 16'hFFFF) begin
                put(K_ID, 0, 0, "R8");
                pc = v;
                jumped = 1;
              end else begin
                put(K_ID, 0, 0, "R9");
              end
            end else if (f == 16'h0000) begin
              put(K_WR, a, v, "R6");
              mm[a[9:0]] = v;
            end else begin
              put(K_ID, 0, 0, "R7");
            end
          end
          default: begin
            put(K_RD, pc, 0, "R3");
            put(K_ID, 0, 0, depth >= 8 ? "R10" : "R3");
            sp = (sp + 1) % 8;
            st[sp] = n;
            n = t;
            t = mm[pc[9:0]];
            pc = pc + 1;
            depth = (depth < 8) ? depth + 1 : 8;
          end
        endcase
      end
    end
    tr_tag[0] = "R1";
  endtask

  task automatic check_cycle(int i);
    bit ok;
    case (tr_kind[i])
      K_RD:    ok = !we && addr == tr_addr[i];
      K_WR:    ok = we && addr == tr_addr[i] && wdata == tr_data[i];
      default: ok = !we;
    endcase
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cycle %0d: we=%b addr=%h wdata=%h expected kind=%0d addr=%h wdata=%h",
               tr_tag[i], i, we, addr, wdata, tr_kind[i], tr_addr[i], tr_data[i]);
    end
  endtask

  task automatic run_prog();
    build_trace();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) begin
      @(negedge clk);
      #1;
      checks++;
      if (we || addr != 16'h0) begin
        failures++;
        $display("FAIL R1 in reset: we=%b addr=%h expected we=0 addr=0000", we, addr);
      end
    end
    rst_n = 1'b1;
    #1;
    check_cycle(0);
    for (int i = 1; i < NCYC; i++) begin
      @(negedge clk);
      #1;
      check_cycle(i);
    end
  endtask

  task automatic jump_word(int at, logic [15:0] target);
    pw(at, enc("LLLS"));
    pw(at + 1, 16'hFFFF);
    pw(at + 2, target);
    pw(at + 3, 16'hFFFF);
  endtask

  function automatic logic [15:0] rnd_lit();
    case ($urandom % 4)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h0200 + 16'($urandom % 256);
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic gen_random(int seed);
    int pos = 0, nl, r;
    logic [15:0] w, lits[8];
    void'($urandom(seed));
    clear_mem();
    while (pos < 380) begin
      if ($urandom % 8 == 0) begin
        jump_word(pos, 16'($urandom % 400));
        pos += 4;
      end else begin
        w = '0;
        nl = 0;
        for (int s = 0; s < 8; s++) begin
          r = $urandom % 10;
          if (r < 3) begin
            w[2*s +: 2] = 2'b11;
            lits[nl] = rnd_lit();
            nl++;
          end else if (r < 5) w[2*s +: 2] = 2'b10;
          else if (r < 7)     w[2*s +: 2] = 2'b00;
          else                w[2*s +: 2] = 2'b01;
        end
        pw(pos, w);
        for (int j = 0; j < nl; j++) pw(pos + 1 + j, lits[j]);
        pos += 1 + nl;
      end
    end
    jump_word(pos, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R6 R8: plain store then jump back to 0
    clear_mem();
    pw(0, enc("LLLS")); pw(1, 16'h0040); pw(2, 16'hBEEF); pw(3, 16'h0000);
    jump_word(4, 16'h0000);
    run_prog();

    // R7 R9: nonzero flag, PC address with zero and partial flags, then a write
    clear_mem();
    pw(0, enc("LLLSLLLS"));
    pw(1, 16'h0050); pw(2, 16'h1111); pw(3, 16'h0001);
    pw(4, 16'hFFFF); pw(5, 16'h2222); pw(6, 16'h0000);
    pw(7, enc("LLLSLLLS"));
    pw(8, 16'hFFFF); pw(9, 16'h3333); pw(10, 16'h8000);
    pw(11, 16'h0060); pw(12, 16'h4444); pw(13, 16'h0000);
    jump_word(14, 16'h0000);
    run_prog();

    // R5: flag built by shifting, rotate through carry
    clear_mem();
    pw(0, enc("LLLRRS")); pw(1, 16'h0070); pw(2, 16'h0005); pw(3, 16'h0002);
    pw(4, enc("LLLRRS")); pw(5, 16'h0071); pw(6, 16'h0007); pw(7, 16'h0003);
    pw(8, enc("LLLRS")); pw(9, 16'h0072); pw(10, 16'h0009); pw(11, 16'h0001);
    jump_word(12, 16'h0000);
    run_prog();

    // R10: deep pushes, wrap, then pops past empty
    clear_mem();
    pw(0, enc("LLLLLLLL"));
    for (int i = 1; i <= 8; i++) pw(i, 16'(i));
    pw(9, enc("LLLLNNNN"));
    for (int i = 10; i <= 13; i++) pw(i, 16'(16'h0100 + i));
    pw(14, enc("NNNNNNNN"));
    pw(15, enc("NNNNNNNN"));
    pw(16, enc("LLLS")); pw(17, 16'h0090); pw(18, 16'h5A5A); pw(19, 16'h0000);
    jump_word(20, 16'h0000);
    run_prog();

    // R2 R3 R4: random mixes of all opcodes and literals
    for (int sd = 1; sd <= 4; sd++) begin
      gen_random(sd * 7919);
      run_prog();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule